// File: doc/BRIEF.md
# Masked AND-XOR Gadget

This block evaluates z = c XOR (a AND b) on operands that arrive split into Boolean shares. The true value of each operand is the XOR of its shares. The result leaves in the same split form, so the plain value never appears on any wire. It is a first-order glitch-resistant building block for protected nonlinear logic. It draws no fresh random bits. The shares of operand c serve as the refresh, and this works because the function is invertible in c.

Cross-share partial products are computed and captured in a bank of registers. No register depends on both shares of the same operand. A purely combinational XOR layer after the registers folds the captured terms into the output shares. The parameter `SHARES` picks the variant. With 2 shares the bank holds four terms. With 3 shares it holds three terms, and the fold layer passes them straight through.

Beats enter and leave through a valid/ready handshake. An input beat is taken on a clock edge where both `in_valid` and `in_ready` are high. Its result is presented one cycle later and held stable until `out_ready` is seen high. The single result stage can be emptied and refilled in the same cycle.

Top module: `masked_andxor`

## Requirements
- R1: With `SHARES`=2, the XOR of the two output shares equals c XOR (a AND b). Here a, b and c are the XORs of their input shares, and bit i of each bus is share i.
- R2: With `SHARES`=3, the XOR of the three output shares equals c XOR (a AND b) for every share assignment.
- R3: A beat accepted at a clock edge is presented with `out_valid` high right after that edge, which gives one cycle of latency.
- R4: With `SHARES`=2, the output shares are exactly as follows:
  - z[0] = (a0&b0)^c0^(a0&b1)
  - z[1] = (a1&b0)^(a1&b1)^c1
- R5: With `SHARES`=3, the output shares are exactly as follows:
  - z[0] = a1b1^a1b2^a2b1^c1
  - z[1] = a2b2^a2b0^a0b2^c2
  - z[2] = a0b0^a0b1^a1b0^c0
- R6: Over all input share assignments, each output sharing with the correct parity occurs equally often for every fixed (a,b,c), and a sharing with the wrong parity never occurs. This means 4 times each for 2 shares over 64 assignments, and 16 times each for 3 shares over 512 assignments.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` and `z_sh` stay unchanged, `in_ready` is low, and beats offered on the inputs are ignored.
- R8: After reset, `out_valid` is low and `in_ready` is high.
- R9: `in_ready` is high whenever `out_ready` is high. A held result drains with no new beat when `in_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat offered |
| in_ready | output | 1 | Gadget can take a beat |
| a_sh | input | SHARES | Shares of operand a |
| b_sh | input | SHARES | Shares of operand b |
| c_sh | input | SHARES | Shares of operand c (the refresh) |
| out_valid | output | 1 | Result shares present |
| out_ready | input | 1 | Consumer takes the result |
| z_sh | output | SHARES | Shares of z = c ^ (a & b) |

## Verification
Two events can fall on the same edge: the result stage drains a finished beat to the consumer, and it loads the next beat. The exhaustive share sweeps provoke this on every edge. They hold `in_valid` and `out_ready` high and offer a new assignment each cycle. Each presented result is judged against the formulas for the beat offered one cycle earlier, so a lost or doubled beat shows up as a share mismatch. A separate stall phase holds `out_ready` low while new beats are offered, and then releases it with no beat pending.

// File: rtl/axg_pkg.sv
package axg_pkg;
  // Number of registered partial-product terms for a given share count.
  function automatic int term_count(input int shares);
    return (shares == 2) ? 4 : shares;
  endfunction
endpackage

// File: rtl/axg_terms.sv
module axg_terms #(
  parameter int SHARES = 2,
  parameter int NTERM  = axg_pkg::term_count(SHARES)
) (
  input  logic [SHARES-1:0] a,
  input  logic [SHARES-1:0] b,
  input  logic [SHARES-1:0] c,
  output logic [NTERM-1:0]  t
);
  generate
    if (SHARES == 2) begin : g_two
      // Each term touches exactly one share of each operand.
      assign t[0] = (a[0] & b[0]) ^ c[0];
      assign t[1] =  a[0] & b[1];
      assign t[2] =  a[1] & b[0];
      assign t[3] = (a[1] & b[1]) ^ c[1];
    end else begin : g_three
      for (genvar i = 0; i < 3; i++) begin : g_term
        localparam int J = (i + 1) % 3;
        localparam int K = (i + 2) % 3;
        // Term i never sees share i of any operand.
        assign t[i] = (a[J] & b[J]) ^ (a[J] & b[K]) ^ (a[K] & b[J]) ^ c[J];
      end
    end
  endgenerate
endmodule

// File: rtl/axg_bank.sv
module axg_bank #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/axg_compress.sv
module axg_compress #(
  parameter int SHARES = 2,
  parameter int NTERM  = axg_pkg::term_count(SHARES)
) (
  input  logic [NTERM-1:0]  t,
  output logic [SHARES-1:0] z
);
  generate
    if (SHARES == 2) begin : g_fold
      assign z[0] = t[0] ^ t[1];
      assign z[1] = t[2] ^ t[3];
    end else begin : g_pass
      assign z = t;
    end
  endgenerate
endmodule

// File: rtl/masked_andxor.sv
module masked_andxor #(
  parameter int SHARES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [SHARES-1:0] a_sh,
  input  logic [SHARES-1:0] b_sh,
  input  logic [SHARES-1:0] c_sh,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [SHARES-1:0] z_sh
);
  localparam int NTERM = axg_pkg::term_count(SHARES);

  logic [NTERM-1:0] term_d;
  logic [NTERM-1:0] term_q;
  logic             load;

  assign in_ready = !out_valid || out_ready;
  assign load     = in_valid && in_ready;

  axg_terms #(.SHARES(SHARES), .NTERM(NTERM)) terms_i (
    .a(a_sh), .b(b_sh), .c(c_sh), .t(term_d)
  );

  axg_bank #(.W(NTERM)) bank_i (
    .clk(clk), .rst_n(rst_n), .load(load), .d(term_d), .q(term_q)
  );

  axg_compress #(.SHARES(SHARES), .NTERM(NTERM)) fold_i (
    .t(term_q), .z(z_sh)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)        out_valid <= 1'b0;
    else if (in_ready) out_valid <= in_valid;
  end

  // R1 / R2: recombined output matches the function of the accepted beat
  a_r1_r2_recombine: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=>
      ((^z_sh) == $past((^c_sh) ^ ((^a_sh) & (^b_sh)))));

  // R3: an accepted beat is presented on the next cycle
  a_r3_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // R7: a stalled result holds its shares and its valid
  a_r7_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(z_sh)));

  // R9: the result leaves only when the consumer takes it
  a_r9_drain: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_valid) |-> $past(out_ready));
endmodule

// File: tb/masked_andxor_tb_top.sv
`timescale 1ns/1ps
module masked_andxor_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 1'b0;

  logic       v2, r2, ov2, or2;
  logic [1:0] a2, b2, c2, z2;
  logic       v3, r3, ov3, or3;
  logic [2:0] a3, b3, c3, z3;

  masked_andxor #(.SHARES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(v2), .in_ready(r2),
    .a_sh(a2), .b_sh(b2), .c_sh(c2),
    .out_valid(ov2), .out_ready(or2), .z_sh(z2)
  );

  masked_andxor #(.SHARES(3)) dut3_i (
    .clk(clk), .rst_n(rst_n), .in_valid(v3), .in_ready(r3),
    .a_sh(a3), .b_sh(b3), .c_sh(c3),
    .out_valid(ov3), .out_ready(or3), .z_sh(z3)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] exp2(input logic [1:0] a, b, c);
    return {(a[1]&b[0]) ^ (a[1]&b[1]) ^ c[1],
            (a[0]&b[0]) ^ c[0] ^ (a[0]&b[1])};
  endfunction

  function automatic logic [2:0] exp3(input logic [2:0] a, b, c);
    logic [2:0] z;
    z[0] = (a[1]&b[1]) ^ (a[1]&b[2]) ^ (a[2]&b[1]) ^ c[1];
    z[1] = (a[2]&b[2]) ^ (a[2]&b[0]) ^ (a[0]&b[2]) ^ c[2];
    z[2] = (a[0]&b[0]) ^ (a[0]&b[1]) ^ (a[1]&b[0]) ^ c[0];
    return z;
  endfunction

  int tally2 [8][4];
  int tally3 [8][8];

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      done = 1'b1;
      fails++;
      tests++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [1:0] pa2, pb2, pc2;
    logic [2:0] pa3, pb3, pc3;
    logic [2:0] hold3;
    v2 = 0; a2 = 0; b2 = 0; c2 = 0; or2 = 1;
    v3 = 0; a3 = 0; b3 = 0; c3 = 0; or3 = 1;
    pa2 = 0; pb2 = 0; pc2 = 0; pa3 = 0; pb3 = 0; pc3 = 0;
    for (int i = 0; i < 8; i++) begin
      for (int j = 0; j < 4; j++) tally2[i][j] = 0;
      for (int j = 0; j < 8; j++) tally3[i][j] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8: reset state
    check(ov2 == 0 && r2 == 1, "R8 two-share idle", {ov2, r2}, 1);
    check(ov3 == 0 && r3 == 1, "R8 three-share idle", {ov3, r3}, 1);

    // Two-share streaming sweep: load and drain on every edge
    for (int k = 0; k <= 64; k++) begin
      if (k > 0) begin
        logic [2:0] combo;
        logic       zt;
        combo = {^pa2, ^pb2, ^pc2};
        zt = (^pc2) ^ ((^pa2) & (^pb2));
        check(ov2 == 1, "R3 two-share valid", ov2, 1);
        check(^z2 == zt, "R1 recombined", ^z2, zt);
        check(z2 == exp2(pa2, pb2, pc2), "R4 share values", z2, exp2(pa2, pb2, pc2));
        tally2[combo][z2]++;
      end
      if (k < 64) begin
        logic [5:0] kk;
        kk = 6'(k);
        a2 = kk[1:0]; b2 = kk[3:2]; c2 = kk[5:4]; v2 = 1;
        pa2 = a2; pb2 = b2; pc2 = c2;
      end else v2 = 0;
      @(negedge clk);
    end
    for (int cb = 0; cb < 8; cb++) begin
      logic [2:0] cc;
      logic zt;
      cc = 3'(cb);
      zt = cc[0] ^ (cc[2] & cc[1]);
      for (int p = 0; p < 4; p++) begin
        logic [1:0] pp;
        pp = 2'(p);
        check(tally2[cb][p] == ((^pp == zt) ? 4 : 0), "R6 two-share uniformity",
              tally2[cb][p], (^pp == zt) ? 4 : 0);
      end
    end

    // Three-share streaming sweep
    for (int k = 0; k <= 512; k++) begin
      if (k > 0) begin
        logic [2:0] combo;
        logic       zt;
        combo = {^pa3, ^pb3, ^pc3};
        zt = (^pc3) ^ ((^pa3) & (^pb3));
        check(ov3 == 1, "R3 three-share valid", ov3, 1);
        check(^z3 == zt, "R2 recombined", ^z3, zt);
        check(z3 == exp3(pa3, pb3, pc3), "R5 share values", z3, exp3(pa3, pb3, pc3));
        tally3[combo][z3]++;
      end
      if (k < 512) begin
        logic [8:0] kk;
        kk = 9'(k);
        a3 = kk[2:0]; b3 = kk[5:3]; c3 = kk[8:6]; v3 = 1;
        pa3 = a3; pb3 = b3; pc3 = c3;
      end else v3 = 0;
      @(negedge clk);
    end
    for (int cb = 0; cb < 8; cb++) begin
      logic [2:0] cc;
      logic zt;
      cc = 3'(cb);
      zt = cc[0] ^ (cc[2] & cc[1]);
      for (int p = 0; p < 8; p++) begin
        logic [2:0] pp;
        pp = 3'(p);
        check(tally3[cb][p] == ((^pp == zt) ? 16 : 0), "R6 three-share uniformity",
              tally3[cb][p], (^pp == zt) ? 16 : 0);
      end
    end

    // R7: stall with new beats offered on the three-share instance
    or3 = 0;
    a3 = 3'b011; b3 = 3'b110; c3 = 3'b101; v3 = 1;
    @(negedge clk);
    hold3 = exp3(3'b011, 3'b110, 3'b101);
    check(ov3 == 1 && z3 == hold3, "R7 stalled result present", z3, hold3);
    check(r3 == 0, "R7 not ready while stalled", r3, 0);
    a3 = 3'b111; b3 = 3'b111; c3 = 3'b000;
    repeat (2) @(negedge clk);
    check(ov3 == 1 && z3 == hold3, "R7 offered beats ignored", z3, hold3);
    // R9: ready follows out_ready, then drain with nothing pending
    or3 = 1;
    #1;
    check(r3 == 1, "R9 ready with consumer ready", r3, 1);
    v3 = 0;
    @(negedge clk);
    check(ov3 == 0, "R9 drained", ov3, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule